// File: doc/BRIEF.md
# Read-Clear Interrupt Collector

This block gathers event conditions from several internal sources, one of them an over-temperature monitor, into a sticky pending register. An active-high output enable drives the pull-down of an open-drain, active-low interrupt request line. The host reads the pending register with a one-cycle read strobe. The value returned is captured in a register, and only the bits carried in that value are cleared. An event that arrives in the same cycle as the read therefore stays pending for the next read.

Each source level passes through a rising-edge detector. A condition that stays active sets its pending bit once, and the bit sets again only after the level drops and rises. A per-source enable decides whether an edge is captured. The raw, qualified condition levels are also presented on a separate status output that reads do not affect. The over-temperature source is only watched while the main regulator is on. An over-temperature event only reports and switches nothing off.

Top module: `irq_readclear_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending register, `src_stat` and `irq_oe` are zero after that edge, and the first read after reset returns zero.
- R2: A rising edge on an enabled source level `src_lvl[i]` sets pending bit i at the next clock edge. Bit i of `rd_data` corresponds to source i, and several sources may be captured together.
- R3: A rising edge on a source whose `src_en[i]` is low sets no pending bit. Its `src_stat[i]` still follows the level.
- R4: A level held high sets its pending bit only once. After the bit is read and cleared, it stays clear while the level remains high. Pending bits never clear without a read.
- R5: A read strobe `rd_stb` high at a clock edge loads `rd_data` with the pending register as it was before that edge. `rd_valid` is high for the following cycle. The returned bits are cleared.
- R6: A source edge captured at the same clock edge as a read is not part of the returned value. It stays pending and appears in the next read.
- R7: `irq_oe` is high one cycle after the pending register becomes non-zero. It is low one cycle after the pending register becomes zero.
- R8: `src_stat` shows the qualified source levels one clock edge after they change, and reads never clear it.
- R9: While `regu_on` is low, the over-temperature source at index `TEMP_IDX` is treated as inactive: its status bit is zero and it raises no pending bit. When `regu_on` rises with the level already high, this counts as a new rising edge.
- R10: Clearing an enable after its bit has been captured leaves the pending bit and `irq_oe` unchanged until the bit is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| src_lvl | input | NSRC | Raw condition level per source |
| src_en | input | NSRC | Capture enable per source |
| regu_on | input | 1 | Main regulator on; gates the over-temperature source |
| rd_stb | input | 1 | One-cycle read-and-clear strobe |
| rd_data | output | NSRC | Pending bits returned by the last read |
| rd_valid | output | 1 | High for one cycle when `rd_data` is fresh |
| src_stat | output | NSRC | Qualified condition levels, not cleared by reads |
| irq_oe | output | 1 | Pull-down enable for the active-low interrupt line |

## Verification
The bench builds the block with `NSRC=5` and `TEMP_IDX=3`. With these values the over-temperature source sits in the middle of the vector rather than at bit 0, so an index mix-up in the regulator gating shows up as a wrong bit. Five sources are enough to set and clear disjoint bit patterns at the same time. They also allow a same-cycle event on one source while another source's bit is being returned, which separates the returned-value clear from a whole-register clear.

// File: rtl/irq_rc_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and helpers for the read-clear interrupt collector.
// Assumes: nothing beyond standard SystemVerilog.
package irq_rc_pkg;
    localparam int DEF_NSRC     = 8;
    localparam int DEF_TEMP_IDX = 0;

    // Read path state: idle or presenting fresh data
    typedef enum logic [0:0] {
        RD_IDLE  = 1'b0,
        RD_FRESH = 1'b1
    } rd_phase_e;
endpackage

// File: rtl/irq_src_cond.sv
`timescale 1ns/1ps
// Module: irq_src_cond
// Qualifies each source level (the over-temperature source is gated by the
// regulator-on input). It registers the qualified levels as status and turns
// rising edges into single-cycle events, kept only when the source is enabled.
// Assumes: src_lvl is synchronous to clk; TEMP_IDX < NSRC.
module irq_src_cond #(
    parameter int NSRC     = 8,
    parameter int TEMP_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic [NSRC-1:0] src_en,
    input  logic            regu_on,
    output logic [NSRC-1:0] stat,
    output logic [NSRC-1:0] evt
);
    logic [NSRC-1:0] qual;
    logic [NSRC-1:0] prev_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == TEMP_IDX) begin : g_temp
            // Over-temperature is only watched while the regulator runs
            always_comb qual[i] = src_lvl[i] & regu_on;
        end else begin : g_plain
            // Ordinary source passes straight through
            always_comb qual[i] = src_lvl[i];
        end
        // Event fires on a rising qualified level of an enabled source
        always_comb evt[i] = qual[i] & ~prev_q[i] & src_en[i];
    end

    // Remember the previous qualified level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= qual;
    end

    // Registered status view of the qualified levels
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= qual;
    end
endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
// Module: irq_pend_bank
// Sticky pending register with an atomic read-and-clear. A read captures the
// current value and clears only the captured bits, so a new event at the same
// edge survives.
// Assumes: rd_stb is a single-cycle strobe synchronous to clk.
module irq_pend_bank
    import irq_rc_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            rd_stb,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] rd_data,
    output logic            rd_valid
);
    rd_phase_e       phase_q;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] pend_nxt;

    // Bits to clear are exactly the ones handed out on this read
    always_comb clr_mask = rd_stb ? pend : '0;

    // Next pending value: keep, drop returned bits, add new events
    always_comb pend_nxt = (pend & ~clr_mask) | evt;

    // Pending register update
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // Capture the returned value on a read
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= pend;
    end

    // Mark the cycle after a read as carrying fresh data
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= RD_IDLE;
        else        phase_q <= rd_stb ? RD_FRESH : RD_IDLE;
    end

    // Valid flag derived from the read phase
    always_comb rd_valid = (phase_q == RD_FRESH);
endmodule

// File: rtl/irq_req_drv.sv
`timescale 1ns/1ps
// Module: irq_req_drv
// Registers the pull-down enable of the active-low interrupt line from the
// OR of the pending bits, so the line never glitches on register updates.
// Assumes: the pad applies the pull-down when irq_oe is high.
module irq_req_drv #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    output logic            irq_oe
);
    // Registered request: any pending bit pulls the line low
    always_ff @(posedge clk) begin
        if (!rst_n) irq_oe <= 1'b0;
        else        irq_oe <= |pend;
    end
endmodule

// File: rtl/irq_readclear_top.sv
`timescale 1ns/1ps
// Module: irq_readclear_top
// Interrupt collector: source conditioning, sticky read-clear bank and
// registered open-drain request enable.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module irq_readclear_top
    import irq_rc_pkg::*;
#(
    parameter int NSRC     = DEF_NSRC,
    parameter int TEMP_IDX = DEF_TEMP_IDX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic [NSRC-1:0] src_en,
    input  logic            regu_on,
    input  logic            rd_stb,
    output logic [NSRC-1:0] rd_data,
    output logic            rd_valid,
    output logic [NSRC-1:0] src_stat,
    output logic            irq_oe
);
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] pend;

    irq_src_cond #(.NSRC(NSRC), .TEMP_IDX(TEMP_IDX)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (src_lvl),
        .src_en  (src_en),
        .regu_on (regu_on),
        .stat    (src_stat),
        .evt     (evt)
    );

    irq_pend_bank #(.NSRC(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .rd_stb   (rd_stb),
        .pend     (pend),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    irq_req_drv #(.NSRC(NSRC)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .irq_oe (irq_oe)
    );
endmodule

// File: rtl/irq_readclear_chk.sv
`timescale 1ns/1ps
// Module: irq_readclear_chk
// Property checker bound to irq_readclear_top.
// Assumes: pend is the top's internal pending vector.
module irq_readclear_chk #(
    parameter int NSRC     = 8,
    parameter int TEMP_IDX = 0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            regu_on,
    input logic            rd_stb,
    input logic [NSRC-1:0] rd_data,
    input logic            rd_valid,
    input logic [NSRC-1:0] src_stat,
    input logic            irq_oe,
    input logic [NSRC-1:0] pend
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && irq_oe == 1'b0 && src_stat == '0));

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (($past(pend) & ~pend) == '0));

    // R5
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_valid && rd_data == $past(pend)));

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |=> irq_oe);

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq_oe);

    // R9
    temp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regu_on |=> !src_stat[TEMP_IDX]);
endmodule

bind irq_readclear_top irq_readclear_chk #(.NSRC(NSRC), .TEMP_IDX(TEMP_IDX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .regu_on  (regu_on),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .src_stat (src_stat),
    .irq_oe   (irq_oe),
    .pend     (pend)
);

// File: tb/irq_readclear_top_tb.sv
`timescale 1ns/1ps
module irq_readclear_top_tb;
    localparam int NSRC = 5;
    localparam int TEMP = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_lvl = '0;
    logic [NSRC-1:0] src_en = '1;
    logic            regu_on = 1'b1;
    logic            rd_stb = 1'b0;
    logic [NSRC-1:0] rd_data;
    logic            rd_valid;
    logic [NSRC-1:0] src_stat;
    logic            irq_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [NSRC-1:0] exp_q[$];
    string           tag_q[$];

    irq_readclear_top #(.NSRC(NSRC), .TEMP_IDX(TEMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .src_en(src_en),
        .regu_on(regu_on), .rd_stb(rd_stb), .rd_data(rd_data),
        .rd_valid(rd_valid), .src_stat(src_stat), .irq_oe(irq_oe)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: queue the expected read value, then pulse the strobe
    task automatic do_read(input logic [NSRC-1:0] expv, input string req);
        exp_q.push_back(expv);
        tag_q.push_back(req);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Monitor: compare each returned value against the queue
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5-unexpected", int'(rd_data), 0);
            end else begin
                automatic logic [NSRC-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, int'(rd_data), int'(e));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(3);
        check(irq_oe == 1'b0, "R1 irq", int'(irq_oe), 0);
        check(src_stat == '0, "R1 stat", int'(src_stat), 0);
        rst_n = 1'b1;
        step(1);
        do_read(5'b00000, "R1 first read");
        step(1);

        // R2, R7, R8: single source
        src_lvl = 5'b00001;
        step(1);
        check(irq_oe == 1'b0, "R7 not yet", int'(irq_oe), 0);
        check(src_stat == 5'b00001, "R8 stat", int'(src_stat), 1);
        step(1);
        check(irq_oe == 1'b1, "R7 raise", int'(irq_oe), 1);
        do_read(5'b00001, "R2 single");
        check(irq_oe == 1'b1, "R7 still", int'(irq_oe), 1);
        step(1);
        check(irq_oe == 1'b0, "R7 release", int'(irq_oe), 0);
        // R4: held level does not re-arm
        step(2);
        do_read(5'b00000, "R4 held level");
        check(src_stat == 5'b00001, "R8 not cleared", int'(src_stat), 1);

        // R2: several sources at once
        src_lvl = 5'b00000;
        step(1);
        src_lvl = 5'b10101;
        step(2);
        do_read(5'b10101, "R2 multi");
        src_lvl = 5'b00000;
        step(2);

        // R3: disabled source captures nothing, status still shows
        src_en = 5'b11101;
        src_lvl = 5'b00010;
        step(2);
        check(src_stat == 5'b00010, "R3 stat", int'(src_stat), 2);
        check(irq_oe == 1'b0, "R3 irq", int'(irq_oe), 0);
        do_read(5'b00000, "R3 masked");
        src_en = '1;
        src_lvl = 5'b00000;
        step(1);

        // R10: disabling after capture keeps the bit
        src_lvl = 5'b00100;
        step(1);
        src_en = 5'b00000;
        step(2);
        check(irq_oe == 1'b1, "R10 irq", int'(irq_oe), 1);
        do_read(5'b00100, "R10 kept");
        src_en = '1;
        src_lvl = 5'b00000;
        step(2);

        // R6: event landing at the read edge stays pending
        src_lvl = 5'b10000;
        step(1);
        exp_q.push_back(5'b10000);
        tag_q.push_back("R6 returned");
        src_lvl = 5'b11000;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        step(1);
        check(irq_oe == 1'b1, "R6 irq", int'(irq_oe), 1);
        do_read(5'b01000, "R6 survivor");
        src_lvl = 5'b00000;
        step(2);

        // R9: temperature source ignored while regulator off
        regu_on = 1'b0;
        src_lvl = 5'b01000;
        step(2);
        check(src_stat[TEMP] == 1'b0, "R9 stat", int'(src_stat), 0);
        do_read(5'b00000, "R9 ignored");
        regu_on = 1'b1;
        step(2);
        check(src_stat == 5'b01000, "R9 resumed stat", int'(src_stat), 8);
        do_read(5'b01000, "R9 resumed");
        src_lvl = 5'b00000;
        step(2);

        // R1: reset mid-operation
        src_lvl = 5'b00001;
        step(2);
        rst_n = 1'b0;
        step(1);
        check(irq_oe == 1'b0, "R1 mid irq", int'(irq_oe), 0);
        check(src_stat == '0, "R1 mid stat", int'(src_stat), 0);
        src_lvl = 5'b00000;
        step(1);
        rst_n = 1'b1;
        step(1);
        do_read(5'b00000, "R1 after reset");
        step(2);

        check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule